// File: doc/BRIEF.md
# Display Timing and Plane Enable Sequencer

This block turns a one-bit on/off request for a display head into an ordered change of two enables: the timing generator enable and the scan-out plane enable. A turn-on raises the timing enable first and asks for the plane one cycle later. A turn-off drops the plane request first and the timing enable on the next cycle. The plane request is only a shadow value. The display pipe copies it into the applied plane bit on a rising vertical sync edge, and only when the pipe signals that it is ready.

On turn-on the sequencer waits until the applied control word matches the requested one. The comparison ignores the bits that are reserved for that head. Every vsync edge that passes without a match counts as one more attempt. When the match is seen, a done pulse is raised and the attempt count is kept. If the retry budget runs out, an error pulse is raised instead. Each head has its own sequencer, its own shadow and its own reserved mask; requests are steered to a head by an index. A request that reaches a head which is still busy is held in a one-deep slot, where a later request replaces an earlier one. It runs as soon as the current sequence ends.

Top module: `dseq_top`

## Requirements
- R1: After reset, every head has timing_en, plane_req, plane_en, busy, done and err at 0, and tries at 0.
- R2: A turn-on request accepted at a clock edge sets timing_en after that edge, and sets plane_req one edge later. plane_req never rises while timing_en was 0 in the previous cycle.
- R3: plane_en changes only on the edge that follows a cycle in which that head saw a rising vsync while pipe_ready was 1. It then takes the value of plane_req.
- R4: During turn-on the head compares the applied word with the requested word. The applied word is built as bit 0 = timing_en, bit 1 = plane_en, bits 2 to 7 = that head's hw_stat bits 0 to 5. The requested word is built as bit 0 = timing_en, bit 1 = plane_req, all other bits 0. When the two words agree on every non-reserved bit, done pulses for exactly one cycle. tries then holds the number of rising vsync edges counted while waiting.
- R5: Head 0 (panel) reserves bits 2 to 7, so none of its hw_stat bits affect completion. Head 1 (CRT) reserves only bits 4 to 7, so its hw_stat bits 0 and 1 must both be 0 for a match.
- R6: If a rising vsync edge arrives while waiting with tries already at RETRY_MAX (default 16), err pulses instead of done. The head returns to idle with timing_en and plane_req still 1, and tries at RETRY_MAX.
- R7: A turn-off request accepted at an edge clears plane_req after that edge. timing_en clears one edge later, and done pulses in that same cycle with tries at 0.
- R8: A request that reaches a head while it is running a sequence is held, and the latest such request wins. It is accepted on the edge after the current sequence ends. busy is 1 while a sequence runs or a request is held.
- R9: req_head selects the head (0 = panel, 1 = CRT). The other head's outputs are not changed by the request.
- R10: A vsync level that stays high counts as a single edge, no matter how long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle |
| req_head | input | 1 | Head index of the request |
| req_on | input | 1 | 1 = turn on, 0 = turn off |
| vsync | input | 2 | Vertical sync level, one bit per head |
| pipe_ready | input | 2 | Pipe accepts the shadow plane bit at vsync |
| hw_stat | input | 12 | Hardware-owned control word bits 2..7, 6 bits per head |
| timing_en | output | 2 | Timing generator enable per head |
| plane_req | output | 2 | Shadow (requested) plane enable per head |
| plane_en | output | 2 | Applied plane enable per head |
| busy | output | 2 | Sequence running or request held |
| done | output | 2 | One-cycle completion pulse |
| err | output | 2 | One-cycle retry-limit pulse |
| tries | output | 10 | Attempt count of the last sequence, 5 bits per head |

## Verification
Some orderings are checked by the assertions on every cycle. The plane request never rises without timing already on, and timing never falls while the plane request is still set. The applied plane bit moves only after a ready vsync, done and err never coincide, and tries never exceeds its limit. Other behaviours only show up in the bench's scenarios, where the cycle model is compared against the outputs: the exact attempt counts, the different reserved masks of the two heads, the expiry of the retry budget, replacement and later service of a held request, and a long vsync level counted once.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_TMON = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_DOWN = 2'd3
   } seq_state_t;

   localparam int TIMING_POS = 0;
   localparam int PLANE_POS  = 1;
   localparam int STAT_LSB   = 2;
endpackage

// File: rtl/dseq_vsync_edge.sv
module dseq_vsync_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync_in,
   output logic rise
);
   logic level;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = vsync_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= vsync_in;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], vsync_in};
         end
         assign level = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
endmodule

// File: rtl/dseq_plane_shadow.sv
module dseq_plane_shadow
   import dseq_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter logic [CTRL_W-1:0] RSVD = '0,
   localparam int SW = CTRL_W - STAT_LSB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          wr_val,
   input  logic          timing,
   input  logic          vs_rise,
   input  logic          ready,
   input  logic [SW-1:0] stat,
   output logic          plane_req,
   output logic          plane_app,
   output logic          match
);
   logic [CTRL_W-1:0] want_word;
   logic [CTRL_W-1:0] seen_word;
   logic [CTRL_W-1:0] keep_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plane_req <= 1'b0;
         plane_app <= 1'b0;
      end else begin
         if (wr) plane_req <= wr_val;
         if (vs_rise && ready) plane_app <= plane_req;
      end
   end

   always_comb begin
      want_word             = '0;
      want_word[TIMING_POS] = timing;
      want_word[PLANE_POS]  = plane_req;
      seen_word             = {stat, plane_app, timing};
      keep_mask             = ~RSVD;
      match                 = ((want_word ^ seen_word) & keep_mask) == '0;
   end
endmodule

// File: rtl/dseq_head_fsm.sv
module dseq_head_fsm
   import dseq_pkg::*;
#(
   parameter int RETRY_MAX = 16,
   localparam int TRY_W = $clog2(RETRY_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             hit_on,
   input  logic             vs_rise,
   input  logic             match,
   output logic             timing,
   output logic             pl_wr,
   output logic             pl_val,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [TRY_W-1:0] tries
);
   seq_state_t st_q;
   logic       hold_v, hold_on;
   logic       take, take_on;

   always_comb begin
      take    = (st_q == SQ_IDLE) && (hold_v || hit);
      take_on = hold_v ? hold_on : hit_on;
      pl_wr   = (st_q == SQ_TMON) || (take && !take_on);
      pl_val  = (st_q == SQ_TMON);
      busy    = (st_q != SQ_IDLE) || hold_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         timing  <= 1'b0;
         hold_v  <= 1'b0;
         hold_on <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         tries   <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (st_q == SQ_IDLE) begin
            if (hold_v) begin
               hold_v <= hit;
               if (hit) hold_on <= hit_on;
            end
         end else if (hit) begin
            hold_v  <= 1'b1;
            hold_on <= hit_on;
         end
         case (st_q)
            SQ_IDLE: begin
               if (take) begin
                  tries <= '0;
                  if (take_on) begin
                     timing <= 1'b1;
                     st_q   <= SQ_TMON;
                  end else begin
                     st_q <= SQ_DOWN;
                  end
               end
            end
            SQ_TMON: st_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (match) begin
                  done <= 1'b1;
                  st_q <= SQ_IDLE;
               end else if (vs_rise) begin
                  if (tries == TRY_W'(RETRY_MAX)) begin
                     err  <= 1'b1;
                     st_q <= SQ_IDLE;
                  end else begin
                     tries <= tries + 1'b1;
                  end
               end
            end
            SQ_DOWN: begin
               timing <= 1'b0;
               done   <= 1'b1;
               st_q   <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dseq_top.sv
module dseq_top
   import dseq_pkg::*;
#(
   parameter int NH          = 2,
   parameter int CTRL_W      = 8,
   parameter int RETRY_MAX   = 16,
   parameter int SYNC_STAGES = 0,
   parameter logic [NH*CTRL_W-1:0] RSVD_MASKS = {8'hF0, 8'hFC},
   localparam int HW    = (NH > 1) ? $clog2(NH) : 1,
   localparam int SW    = CTRL_W - STAT_LSB,
   localparam int TRY_W = $clog2(RETRY_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [HW-1:0]       req_head,
   input  logic                req_on,
   input  logic [NH-1:0]       vsync,
   input  logic [NH-1:0]       pipe_ready,
   input  logic [NH*SW-1:0]    hw_stat,
   output logic [NH-1:0]       timing_en,
   output logic [NH-1:0]       plane_req,
   output logic [NH-1:0]       plane_en,
   output logic [NH-1:0]       busy,
   output logic [NH-1:0]       done,
   output logic [NH-1:0]       err,
   output logic [NH*TRY_W-1:0] tries
);
   generate
      if (NH < 1) begin : g_bad_nh
         $error("dseq_top: NH must be at least 1");
      end
      if (CTRL_W < 3) begin : g_bad_w
         $error("dseq_top: CTRL_W must leave room for status bits");
      end
      if (RETRY_MAX < 1) begin : g_bad_retry
         $error("dseq_top: RETRY_MAX must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("dseq_top: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NH-1:0] vs_rise;
   logic [NH-1:0] hit;
   logic [NH-1:0] match;
   logic [NH-1:0] pl_wr;
   logic [NH-1:0] pl_val;

   for (genvar h = 0; h < NH; h++) begin : g_head
      localparam logic [CTRL_W-1:0] HEAD_RSVD = RSVD_MASKS[h*CTRL_W +: CTRL_W];

      if (HEAD_RSVD[TIMING_POS] || HEAD_RSVD[PLANE_POS]) begin : g_bad_mask
         $error("dseq_top: enable bits may not be reserved");
      end

      assign hit[h] = req_valid && (req_head == HW'(h));

      dseq_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .vsync_in (vsync[h]),
         .rise     (vs_rise[h])
      );

      dseq_head_fsm #(.RETRY_MAX(RETRY_MAX)) u_fsm (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (hit[h]),
         .hit_on  (req_on),
         .vs_rise (vs_rise[h]),
         .match   (match[h]),
         .timing  (timing_en[h]),
         .pl_wr   (pl_wr[h]),
         .pl_val  (pl_val[h]),
         .busy    (busy[h]),
         .done    (done[h]),
         .err     (err[h]),
         .tries   (tries[h*TRY_W +: TRY_W])
      );

      dseq_plane_shadow #(.CTRL_W(CTRL_W), .RSVD(HEAD_RSVD)) u_shadow (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr        (pl_wr[h]),
         .wr_val    (pl_val[h]),
         .timing    (timing_en[h]),
         .vs_rise   (vs_rise[h]),
         .ready     (pipe_ready[h]),
         .stat      (hw_stat[h*SW +: SW]),
         .plane_req (plane_req[h]),
         .plane_app (plane_en[h]),
         .match     (match[h])
      );
   end
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
   parameter int NH          = 2,
   parameter int RETRY_MAX   = 16,
   parameter int SYNC_STAGES = 0,
   parameter int TRY_W       = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NH-1:0]       vsync,
   input logic [NH-1:0]       pipe_ready,
   input logic [NH-1:0]       timing_en,
   input logic [NH-1:0]       plane_req,
   input logic [NH-1:0]       plane_en,
   input logic [NH-1:0]       done,
   input logic [NH-1:0]       err,
   input logic [NH*TRY_W-1:0] tries
);
   for (genvar h = 0; h < NH; h++) begin : g_chk
      AST_PLANE_AFTER_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(plane_req[h]) |-> $past(timing_en[h])); // R2

      AST_TIMING_AFTER_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(timing_en[h]) |-> $past(!plane_req[h])); // R7

      if (SYNC_STAGES == 0) begin : g_direct
         AST_APPLY_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(plane_en[h]) |-> $past(vsync[h] && pipe_ready[h])); // R3
      end

      AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
         !(done[h] && err[h])); // R6

      AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         done[h] |=> !done[h]); // R4

      AST_ERR_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
         err[h] |-> (timing_en[h] && plane_req[h])); // R6

      AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         tries[h*TRY_W +: TRY_W] <= TRY_W'(RETRY_MAX)); // R6
   end
endmodule

bind dseq_top dseq_chk #(
   .NH(NH), .RETRY_MAX(RETRY_MAX), .SYNC_STAGES(SYNC_STAGES), .TRY_W(TRY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vsync(vsync), .pipe_ready(pipe_ready),
   .timing_en(timing_en), .plane_req(plane_req), .plane_en(plane_en),
   .done(done), .err(err), .tries(tries)
);

// File: tb/sim_dseq_top.sv
`timescale 1ns/1ps
module sim_dseq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [0:0]  req_head = 1'b0;
   logic        req_on = 1'b0;
   logic [1:0]  vsync = 2'b00;
   logic [1:0]  pipe_ready = 2'b00;
   logic [11:0] hw_stat = '0;
   logic [1:0]  timing_en, plane_req, plane_en, busy, done, err;
   logic [9:0]  tries;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;
   bit seen_done [2];
   bit seen_err  [2];

   // behavioural model: 0 idle, 1 timing on, 2 waiting, 3 turning off
   int m_st [2], m_tim [2], m_psh [2], m_papp [2], m_hv [2], m_hon [2];
   int m_done [2], m_err [2], m_try [2], m_vprev [2];
   localparam int LIMIT = 16;

   always #5 clk = ~clk;

   dseq_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
      .req_on(req_on), .vsync(vsync), .pipe_ready(pipe_ready), .hw_stat(hw_stat),
      .timing_en(timing_en), .plane_req(plane_req), .plane_en(plane_en),
      .busy(busy), .done(done), .err(err), .tries(tries)
   );

   function automatic bit head_ok(int h);
      if (h == 0) return 1'b1;
      return hw_stat[7:6] == 2'b00;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int h = 0; h < 2; h++) begin
            m_st[h] = 0; m_tim[h] = 0; m_psh[h] = 0; m_papp[h] = 0; m_hv[h] = 0;
            m_hon[h] = 0; m_done[h] = 0; m_err[h] = 0; m_try[h] = 0; m_vprev[h] = 0;
         end
      end else begin
         for (int h = 0; h < 2; h++) begin
            bit vr, r, ok;
            int n_st, n_tim, n_psh, n_papp, n_hv, n_hon, n_try, n_done, n_err;
            vr = vsync[h] && !m_vprev[h];
            r = req_valid && (req_head == h);
            ok = m_tim[h] == 1 && m_papp[h] == m_psh[h] && head_ok(h);
            n_st = m_st[h]; n_tim = m_tim[h]; n_psh = m_psh[h]; n_hv = m_hv[h];
            n_hon = m_hon[h]; n_try = m_try[h]; n_done = 0; n_err = 0;
            n_papp = (vr && pipe_ready[h]) ? m_psh[h] : m_papp[h];
            if (m_st[h] == 0) begin
               bit go, on;
               go = m_hv[h] || r;
               on = m_hv[h] ? m_hon[h] : req_on;
               if (m_hv[h]) begin n_hv = r; if (r) n_hon = req_on; end
               if (go) begin
                  n_try = 0;
                  if (on) begin n_tim = 1; n_st = 1; end
                  else begin n_psh = 0; n_st = 3; end
               end
            end else if (r) begin
               n_hv = 1; n_hon = req_on;
            end
            case (m_st[h])
               1: begin n_psh = 1; n_st = 2; end
               2: begin
                  if (ok) begin n_done = 1; n_st = 0; end
                  else if (vr) begin
                     if (m_try[h] == LIMIT) begin n_err = 1; n_st = 0; end
                     else n_try = m_try[h] + 1;
                  end
               end
               3: begin n_tim = 0; n_done = 1; n_st = 0; end
               default: ;
            endcase
            m_st[h] = n_st; m_tim[h] = n_tim; m_psh[h] = n_psh; m_papp[h] = n_papp;
            m_hv[h] = n_hv; m_hon[h] = n_hon; m_try[h] = n_try; m_done[h] = n_done;
            m_err[h] = n_err; m_vprev[h] = vsync[h];
         end
      end
   end

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      total++;
      if (!good) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int h = 0; h < 2; h++) begin
            int ty;
            ty = int'(tries[h*5 +: 5]);
            chk(timing_en[h] == m_tim[h][0], "R2 timing_en", timing_en[h], m_tim[h]);
            chk(plane_req[h] == m_psh[h][0], "R2 plane_req", plane_req[h], m_psh[h]);
            chk(plane_en[h] == m_papp[h][0], "R3 plane_en", plane_en[h], m_papp[h]);
            chk(done[h] == m_done[h][0], "R4 done", done[h], m_done[h]);
            chk(err[h] == m_err[h][0], "R6 err", err[h], m_err[h]);
            chk(ty == m_try[h], "R4 tries", ty, m_try[h]);
            chk(busy[h] == (m_st[h] != 0 || m_hv[h] != 0), "R8 busy", busy[h],
                int'(m_st[h] != 0 || m_hv[h] != 0));
            if (done[h]) seen_done[h] = 1;
            if (err[h]) seen_err[h] = 1;
         end
      end
   end

   task automatic req(input int h, input bit on);
      @(negedge clk);
      req_valid = 1'b1; req_head = h[0]; req_on = on;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic vpulse(input int h, input int hi);
      @(negedge clk); vsync[h] = 1'b1;
      repeat (hi) @(negedge clk);
      vsync[h] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flags();
      seen_done[0] = 0; seen_done[1] = 0; seen_err[0] = 0; seen_err[1] = 0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         chk(1'b0, "watchdog", cycles, 100000);
         summary();
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      chk({timing_en, plane_req, plane_en, busy, done, err} == '0, "R1 reset outputs",
          {timing_en, plane_req, plane_en, busy, done, err}, 0);
      chk(tries == '0, "R1 reset tries", tries, 0);
      rst_n = 1'b1;
      idle(2);

      // panel on, ready, first vsync applies
      pipe_ready = 2'b11; clear_flags();
      req(0, 1'b1);
      idle(2);
      vpulse(0, 2);
      idle(2);
      chk(seen_done[0], "R4 panel on done", seen_done[0], 1);
      chk(tries[4:0] == 5'd1, "R4 panel tries", tries[4:0], 1);
      chk(timing_en[1] == 1'b0 && plane_req[1] == 1'b0, "R9 crt untouched",
          {timing_en[1], plane_req[1]}, 0);

      // panel off
      clear_flags();
      req(0, 1'b0);
      idle(3);
      chk(seen_done[0] && timing_en[0] == 1'b0 && plane_req[0] == 1'b0, "R7 off sequence",
          {seen_done[0], timing_en[0], plane_req[0]}, 4);
      vpulse(0, 1);

      // panel on with pipe not ready for two vsyncs, noisy status ignored
      pipe_ready[0] = 1'b0; hw_stat[5:0] = 6'h3F; clear_flags();
      req(0, 1'b1);
      vpulse(0, 2);
      vpulse(0, 1);
      // long vsync level while not ready counts once
      @(negedge clk); vsync[0] = 1'b1;
      idle(20);
      chk(tries[4:0] == 5'd3, "R10 long vsync once", tries[4:0], 3);
      vsync[0] = 1'b0; pipe_ready[0] = 1'b1;
      idle(2);
      // pending request while busy: off then on, latest wins (on)
      req(0, 1'b0);
      req(0, 1'b1);
      chk(busy[0], "R8 busy while held", busy[0], 1);
      vpulse(0, 1);
      idle(10);
      chk(seen_done[0] && tries[4:0] == 5'd0 && timing_en[0] && plane_req[0],
          "R8 held request served", tries[4:0], 0);
      chk(seen_done[0], "R5 panel status ignored", seen_done[0], 1);

      // CRT with status bits 4..7 set: reserved, completes
      hw_stat[11:6] = 6'b111100; clear_flags();
      req(1, 1'b1);
      idle(2);
      vpulse(1, 1);
      idle(2);
      chk(seen_done[1] && !seen_err[1], "R5 crt reserved ignored", seen_done[1], 1);
      req(1, 1'b0);
      idle(3);
      vpulse(1, 1);

      // CRT with compared bit set: never matches, retry limit
      hw_stat[11:6] = 6'b000001; clear_flags();
      req(1, 1'b1);
      idle(2);
      for (int i = 0; i < LIMIT + 1; i++) vpulse(1, 1);
      idle(2);
      chk(seen_err[1] && !seen_done[1], "R6 retry limit err", seen_err[1], 1);
      chk(tries[9:5] == 5'd16, "R6 tries at limit", tries[9:5], 16);
      chk(timing_en[1] && plane_req[1] && !busy[1], "R6 enables kept",
          {timing_en[1], plane_req[1], busy[1]}, 6);

      hw_stat = '0; clear_flags();
      req(1, 1'b0);
      idle(4);
      chk(seen_done[1] && !timing_en[1], "R7 crt off", timing_en[1], 0);
      idle(5);
      summary();
   end
endmodule